// File: doc/BRIEF.md
# Command-Queue I2C Master

This block is a single-master I2C bus engine fed by a queue of tagged command words. Each 10-bit word carries a byte in its low eight bits and two flags above it: one asks for a START (or a repeated START when the engine already holds the bus) ahead of the byte, the other asks for a STOP once that byte, or the read it sets up, has finished. A flagged START word sends its byte as the address byte. Later unflagged words are written as data. After a read address, the next word gives a byte count, and the engine then clocks in that many bytes and places them into a receive queue. No software is involved in each byte.

Both queues are stream interfaces. A command word is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls while the command queue is full or while the queue reset control is held. A received byte leaves on an edge where `rx_valid` and `rx_ready` are both high. When the receive queue is full, the engine does not start the next byte and holds SCL low until space frees up. The bus pins are open-drain style: `scl_oe`/`sda_oe` high pulls the line low. A passive monitor follows the bus lines to derive a busy flag. Status bits, zero-based occupancy counts and one-cycle event pulses go to a separate interrupt block.

Top module: `i2c_cmd_master`

## Requirements
- R1: The command queue holds DEPTH (16) words. `cmd_ready` is low when it is full. `tx_occ` reports the number of stored words minus one, and reads 0 when the queue is empty.
- R2: The receive queue holds DEPTH (16) bytes. `rx_occ` is zero based in the same way. With the queue full, no further byte is clocked in, the engine keeps SCL driven low, and the bus stays busy until bytes are drained.
- R3: Command word layout: bits 7:0 hold the byte, bit 8 requests START, bit 9 requests STOP. A START word produces a START condition, or a repeated START if the engine holds the bus, then sends its byte as the address, with bit 0 = 1 meaning read.
- R4: An unflagged word sent while the engine owns the bus is transmitted MSB first. The engine releases SDA in the ninth clock to take the acknowledge. A set STOP flag ends the transfer with a STOP after that byte.
- R5: A word carrying both START and STOP sends the address alone and then a STOP.
- R6: After an acknowledged read address, the next word's bits 7:0 give the byte count (0..255). The engine ACKs every received byte except the last, which it NACKs. With bit 9 set in the count word a STOP follows; otherwise the bus is held for a repeated START.
- R7: A NACK on an address or written byte pulses `ev_tx_err` and issues a STOP. Unflagged words taken while the engine does not own the bus are discarded, and nothing appears on the bus for them.
- R8: Finishing a read (the NACKed last byte) also pulses `ev_tx_err`.
- R9: `rx_wmark` holds a zero-based level N. `ev_rx_full` pulses once, in the cycle the receive queue count reaches N+1.
- R10: With `ctrl_enable` low, no new command word is taken. While `ctrl_txrst` is high, the command queue is emptied and kept empty, and `cmd_ready` is low.
- R11: `status` bit 7 = command queue empty, bit 6 = receive queue empty, bit 5 = receive queue full, bit 4 = command queue full, bit 2 = bus busy. All other bits read 0.
- R12: Bus busy sets on a START seen on the lines (SDA falling while SCL is high) and clears on a STOP (SDA rising while SCL is high). `ev_bus_idle` pulses in the cycle that clears it.
- R13: Every bit lasts four phases of `clk_div`+1 clock cycles each, so successive SCL rising edges are 4*(`clk_div`+1) cycles apart. SDA changes only while SCL is low, except in START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable | input | 1 | Engine enable; low stops new words being taken |
| ctrl_txrst | input | 1 | Empties the command queue and holds it empty |
| rx_wmark | input | 4 | Zero-based receive level for `ev_rx_full` |
| clk_div | input | 8 | Bus phase length minus one, in clock cycles |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command queue can accept |
| cmd_data | input | 10 | Command word {stop, start, byte} |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Oldest received byte |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| status | output | 8 | Status flags (see R11) |
| tx_occ | output | 4 | Command queue count minus one |
| rx_occ | output | 4 | Receive queue count minus one |
| ev_tx_err | output | 1 | NACK or read completion pulse |
| ev_rx_full | output | 1 | Receive level reached pulse |
| ev_bus_idle | output | 1 | Bus became free pulse |

## Verification
The assertions check on every cycle that SDA holds still while SCL is released during a byte, that no byte is pushed into a full receive queue, and that an accepted command word raises the count. They also check that an error pulse leads only to a STOP or to idle, that the level pulse fires only at the programmed count, and that the bus-free pulse clears the busy flag. The bench scenarios are what show the bus-level results. A bus slave model takes written bytes and returns a computed read pattern, and the scenarios check write and read lengths at two divider settings, address-only and refused-address transfers, a repeated START, receive back-pressure holding the clock low, watermark firing, queue full and reset, and the enable gate.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CMD_W     = 10;
  localparam int START_BIT = 8;
  localparam int STOP_BIT  = 9;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a word; SCL held low if the bus is owned
    S_START,  // START or repeated START, four phases
    S_BYTE,   // eight data bits plus acknowledge
    S_CNT,    // waiting for the read count word
    S_RXW,    // waiting for receive space before the next byte
    S_STOP    // STOP condition, four phases
  } seq_state_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign in_ready  = (count != FULL_CNT) && !flush;
  assign out_valid = (count != '0) && !flush;
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  // R1/R2: an accepted word with no pop raises the count by one
  a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             cmd_pop,
  input  logic             rx_space,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             ev_err
);
  seq_state_t       st;
  logic [DIV_W-1:0] dcnt;
  logic             tick, own, rdaddr, addr, rxm, lastb, stopf, smp;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh, cnt;
  logic             ack_end;

  assign tick    = (dcnt == div);
  assign cmd_pop = cmd_valid && ((st == S_IDLE && enable) || st == S_CNT);
  assign ack_end = (st == S_BYTE) && tick && (ph == 2'd3) && (bitn == 4'd8);
  assign rx_push = (st == S_BYTE) && tick && (ph == 2'd3) && (bitn == 4'd7) && rxm;
  assign rx_byte = {sh[6:0], smp};
  assign ev_err  = ack_end && ((!rxm && smp) || (rxm && lastb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (st == S_START || st == S_BYTE || st == S_STOP) dcnt <= tick ? '0 : dcnt + 1'b1;
    else dcnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; cnt <= '0; smp <= 1'b1;
      own <= 1'b0; rdaddr <= 1'b0; addr <= 1'b0; rxm <= 1'b0; lastb <= 1'b0; stopf <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_pop) begin
          sh    <= cmd_data[7:0];
          stopf <= cmd_data[STOP_BIT];
          ph    <= '0;
          bitn  <= '0;
          if (cmd_data[START_BIT]) begin
            st <= S_START; rdaddr <= cmd_data[0];
          end else if (own) begin
            st <= S_BYTE; rxm <= 1'b0; addr <= 1'b0;
          end
        end
        S_START: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            st <= S_BYTE; own <= 1'b1; addr <= 1'b1; rxm <= 1'b0; bitn <= '0;
          end
        end
        S_BYTE: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd2) smp <= sda_in;
          if (ph == 2'd3) begin
            if (bitn != 4'd8) begin
              sh   <= {sh[6:0], smp};
              bitn <= bitn + 4'd1;
            end else begin
              bitn <= '0;
              addr <= 1'b0;
              if (!rxm) begin
                if (smp)                st <= S_STOP;
                else if (addr && rdaddr) st <= S_CNT;
                else if (stopf)          st <= S_STOP;
                else                     st <= S_IDLE;
              end else begin
                cnt <= cnt - 8'd1;
                if (lastb) st <= stopf ? S_STOP : S_IDLE;
                else       st <= S_RXW;
              end
            end
          end
        end
        S_CNT: if (cmd_pop) begin
          cnt   <= cmd_data[7:0];
          stopf <= cmd_data[STOP_BIT];
          if (cmd_data[7:0] == 8'd0) st <= cmd_data[STOP_BIT] ? S_STOP : S_IDLE;
          else                       st <= S_RXW;
          ph <= '0;
        end
        S_RXW: if (rx_space) begin
          st <= S_BYTE; rxm <= 1'b1; bitn <= '0; ph <= '0; lastb <= (cnt == 8'd1);
        end
        S_STOP: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            st <= S_IDLE; own <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = own;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd0 && own) || ph == 2'd3;
        sda_oe = ph[1];
      end
      S_BYTE: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (bitn == 4'd8) ? (rxm && !lastb) : (!rxm && !sh[7]);
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = !ph[1];
      end
      default: ;
    endcase
  end

  // R13: while SCL is released inside a byte, SDA drive holds still
  a_r13_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
  // R2: a received byte is only pushed when the queue has room
  a_r2_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_space);
  // R7/R8: an error or completion pulse leads to STOP or idle
  a_r7_err_then_close: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (st == S_STOP || st == S_IDLE));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_enable,
  input  logic                      ctrl_txrst,
  input  logic [$clog2(DEPTH)-1:0]  rx_wmark,
  input  logic [DIV_W-1:0]          clk_div,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [CMD_W-1:0]          cmd_data,
  output logic                      rx_valid,
  input  logic                      rx_ready,
  output logic [7:0]                rx_data,
  input  logic                      scl_in,
  input  logic                      sda_in,
  output logic                      scl_oe,
  output logic                      sda_oe,
  output logic [7:0]                status,
  output logic [$clog2(DEPTH)-1:0]  tx_occ,
  output logic [$clog2(DEPTH)-1:0]  rx_occ,
  output logic                      ev_tx_err,
  output logic                      ev_rx_full,
  output logic                      ev_bus_idle
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0]      tx_cnt, rx_cnt, rx_cnt_q;
  logic             q_valid, q_pop, rx_space, rx_push;
  logic [CMD_W-1:0] q_data;
  logic [7:0]       rx_byte;
  logic             scl_d, sda_d, busy, start_det, stop_det;

  i2cm_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_txrst),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_data(cmd_data),
    .out_valid(q_valid), .out_ready(q_pop), .out_data(q_data), .count(tx_cnt));

  i2cm_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(1'b0),
    .in_valid(rx_push), .in_ready(rx_space), .in_data(rx_byte),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data), .count(rx_cnt));

  i2cm_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_enable), .div(clk_div),
    .cmd_valid(q_valid), .cmd_data(q_data), .cmd_pop(q_pop),
    .rx_space(rx_space), .rx_push(rx_push), .rx_byte(rx_byte),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .ev_err(ev_tx_err));

  // bus-line monitor
  assign start_det   = scl_d && scl_in && sda_d && !sda_in;
  assign stop_det    = scl_d && scl_in && !sda_d && sda_in;
  assign ev_bus_idle = busy && stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1; sda_d <= 1'b1; busy <= 1'b0; rx_cnt_q <= '0;
    end else begin
      scl_d    <= scl_in;
      sda_d    <= sda_in;
      rx_cnt_q <= rx_cnt;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  assign ev_rx_full = (rx_cnt == ({1'b0, rx_wmark} + 1'b1)) && (rx_cnt != rx_cnt_q);
  assign tx_occ = (tx_cnt == '0) ? '0 : AW'(tx_cnt - 1'b1);
  assign rx_occ = (rx_cnt == '0) ? '0 : AW'(rx_cnt - 1'b1);
  assign status = {tx_cnt == '0, rx_cnt == '0, rx_cnt == FULL_CNT, tx_cnt == FULL_CNT,
                   1'b0, busy, 2'b00};

  // R12: bus-free pulse clears the busy flag
  a_r12_idle_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_idle |=> !status[2]);
  // R9: level pulse only at the programmed zero-based count
  a_r9_level_match: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_full |-> (rx_occ == rx_wmark && rx_valid));
endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       ctrl_enable = 1'b0, ctrl_txrst = 1'b0;
  logic [3:0] rx_wmark = 4'd15;
  logic [7:0] clk_div = 8'd3;
  logic       cmd_valid = 1'b0, cmd_ready, rx_valid, rx_ready = 1'b0;
  logic [9:0] cmd_data = '0;
  logic [7:0] rx_data, status;
  logic       scl_oe, sda_oe, ev_tx_err, ev_rx_full, ev_bus_idle;
  logic [3:0] tx_occ, rx_occ;
  logic       sl_drv = 1'b0;
  wire        scl = !scl_oe;
  wire        sda = !(sda_oe || sl_drv);

  i2c_cmd_master u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .ctrl_txrst(ctrl_txrst),
    .rx_wmark(rx_wmark), .clk_div(clk_div), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status),
    .tx_occ(tx_occ), .rx_occ(rx_occ), .ev_tx_err(ev_tx_err), .ev_rx_full(ev_rx_full),
    .ev_bus_idle(ev_bus_idle));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] rpat(input int k); return 8'((k * 37 + 5) & 255); endfunction
  function automatic logic [7:0] wpat(input int l, input int i); return 8'((l * 16 + i * 7 + 3) & 255); endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus slave model, address 0x2A, evaluated away from the active edge
  localparam logic [6:0] SLV = 7'h2A;
  logic [7:0] wlog [64];
  logic [7:0] rbuf [64];
  int wcnt = 0, rn = 0, n_start = 0, n_stop = 0, n_addr = 0;
  int errc = 0, rfc = 0, bnbc = 0, cyc = 0, last_rise = 0, rise_gap = 0;
  int sl_ph = 0, bitc = 0, bidx = 0;
  bit isadr, ackph, match, srd, mack, sq = 1'b1, dq = 1'b1;
  logic [7:0] shr, tb;

  always @(negedge clk) begin
    bit s, d;
    s = scl; d = sda; cyc++;
    if (rx_valid && rx_ready) begin rbuf[rn % 64] = rx_data; rn++; end
    if (ev_tx_err) errc++;
    if (ev_rx_full) rfc++;
    if (ev_bus_idle) bnbc++;
    if (sq && s && dq && !d) begin
      sl_ph = 1; bitc = 0; isadr = 1; ackph = 0; sl_drv = 0; n_start++;
    end else if (sq && s && !dq && d) begin
      sl_ph = 0; sl_drv = 0; n_stop++;
    end else if (!sq && s) begin
      rise_gap = cyc - last_rise; last_rise = cyc;
      if (sl_ph == 1 && bitc < 8) begin shr = {shr[6:0], d}; bitc++; end
      if (sl_ph == 2 && bitc == 8) mack = d;
    end else if (sq && !s) begin
      if (sl_ph == 1 && bitc == 8) begin
        if (!ackph) begin
          ackph = 1;
          if (isadr) begin
            match = (shr[7:1] == SLV); srd = shr[0]; sl_drv = match;
            if (match) n_addr++;
          end else begin
            wlog[wcnt % 64] = shr; wcnt++; sl_drv = 1;
          end
        end else begin
          ackph = 0; sl_drv = 0;
          if (!match) sl_ph = 0;
          else if (isadr && srd) begin
            sl_ph = 2; bidx = 0; tb = rpat(0); bitc = 0; sl_drv = !tb[7];
          end else begin bitc = 0; isadr = 0; end
        end
      end else if (sl_ph == 2) begin
        if (bitc < 7) begin bitc++; sl_drv = !tb[7 - bitc]; end
        else if (bitc == 7) begin bitc = 8; sl_drv = 0; end
        else if (!mack) begin bidx++; tb = rpat(bidx); bitc = 0; sl_drv = !tb[7]; end
        else begin sl_ph = 0; sl_drv = 0; end
      end
    end
    sq = s; dq = d;
  end

  task automatic push(input logic [9:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int st = 0;
    while (st < 40) begin
      @(negedge clk);
      if (!status[2] && status[7] && !scl_oe) st++; else st = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, e0, b0, s0, p0, r0, a0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 R1 reset state
    check("R11 reset status", status, 8'hC0);
    check("R1 reset tx_occ", tx_occ, 0);
    check("R13 reset lines released", {scl_oe, sda_oe}, 0);
    ctrl_enable = 1'b1;

    // R3 R4 R12 R13: write lengths 1..4, two divider settings
    for (int l = 1; l <= 4; l++) begin
      clk_div = (l % 2) ? 8'd1 : 8'd3;
      w0 = wcnt; e0 = errc; b0 = bnbc; s0 = n_start;
      push(10'h154);
      for (int i = 0; i < l; i++) push({(i == l - 1), 1'b0, wpat(l, i)});
      wait_idle();
      check("R4 write count", wcnt - w0, l);
      for (int i = 0; i < l; i++) check("R4 write byte", wlog[(w0 + i) % 64], wpat(l, i));
      check("R3 one start", n_start - s0, 1);
      check("R7 no error on ack", errc - e0, 0);
      check("R12 bus idle pulse", bnbc - b0, 1);
      check("R13 bit period", rise_gap, 4 * (clk_div + 1));
    end
    clk_div = 8'd3;

    // R5 address only
    w0 = wcnt; a0 = n_addr; p0 = n_stop; e0 = errc;
    push(10'h354);
    wait_idle();
    check("R5 address seen", n_addr - a0, 1);
    check("R5 no data", wcnt - w0, 0);
    check("R5 stop", n_stop - p0, 1);
    check("R5 no error", errc - e0, 0);

    // R7 refused address, orphan words discarded
    w0 = wcnt; e0 = errc; p0 = n_stop;
    push(10'h160); push(10'h0AA); push(10'h2BB);
    wait_idle();
    check("R7 error pulse", errc - e0, 1);
    check("R7 stop after nack", n_stop - p0, 1);
    check("R7 orphans not written", wcnt - w0, 0);
    check("R7 queue drained", tx_occ, 0);

    // R6 R8 reads of 1..3 bytes
    rx_ready = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      r0 = rn; e0 = errc; b0 = bnbc;
      push(10'h155); push(10'h200 | 10'(n));
      wait_idle();
      check("R6 read count", rn - r0, n);
      for (int k = 0; k < n; k++) check("R6 read byte", rbuf[(r0 + k) % 64], rpat(k));
      check("R8 completion pulse", errc - e0, 1);
      check("R12 bus idle after read", bnbc - b0, 1);
    end

    // R2 R9 back-pressure: 18 bytes with the consumer stalled
    rx_ready = 1'b0; rx_wmark = 4'd15; r0 = rn; e0 = rfc;
    push(10'h155); push(10'h212);
    while (!status[5]) @(negedge clk);
    repeat (300) @(negedge clk);
    check("R2 rx_occ full", rx_occ, 15);
    check("R2 scl held low", scl_oe, 1);
    check("R2 bus kept busy", status[2], 1);
    check("R9 level pulse at 16", rfc - e0, 1);
    rx_ready = 1'b1;
    wait_idle();
    check("R2 all bytes", rn - r0, 18);
    for (int k = 0; k < 18; k++) check("R2 byte order", rbuf[(r0 + k) % 64], rpat(k));

    // R9 watermark 2
    rx_ready = 1'b0; rx_wmark = 4'd2; r0 = rn; e0 = rfc;
    push(10'h155); push(10'h203);
    wait_idle();
    check("R9 occupancy", rx_occ, 2);
    check("R9 one pulse", rfc - e0, 1);
    check("R11 rx not empty", status[6], 0);
    rx_ready = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 rx empty", status[6], 1);
    check("R9 drained bytes", rbuf[(r0 + 2) % 64], rpat(2));

    // R3 R6 repeated start: write one byte then read two
    w0 = wcnt; r0 = rn; s0 = n_start; p0 = n_stop; b0 = bnbc;
    push(10'h154); push(10'h011); push(10'h155); push(10'h202);
    wait_idle();
    check("R3 two starts", n_start - s0, 2);
    check("R3 one stop", n_stop - p0, 1);
    check("R12 single idle pulse", bnbc - b0, 1);
    check("R4 byte before restart", wlog[w0 % 64], 8'h11);
    check("R6 read after restart", rbuf[(r0 + 1) % 64], rpat(1));

    // R10 R1 enable gate, queue full, queue reset
    ctrl_enable = 1'b0;
    for (int i = 0; i < 16; i++) push(10'h0FF);
    repeat (50) @(negedge clk);
    check("R10 nothing taken while disabled", tx_occ, 15);
    check("R1 full flag", status[4], 1);
    check("R1 ready low when full", cmd_ready, 0);
    ctrl_txrst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 reset empties", status[7], 1);
    check("R10 ready low in reset", cmd_ready, 0);
    ctrl_txrst = 1'b0;
    w0 = wcnt;
    push(10'h0EE);
    ctrl_enable = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 orphan discarded", status[7], 1);
    check("R7 orphan not on bus", wcnt - w0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule